// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins a host-side data line to a card-side data line when neither end has a fixed role. Both lines are open-drain. Each side of the block is modelled as a sensed level input and a pull-low enable output. While the block is idle, neither side is driven. The first line seen to fall claims the transfer, and the block then copies that line's level onto the opposite line. The claim ends when the claiming line rises again, and the block returns to the idle state.

The same arbiter is repeated for every line pair, meaning the main data pair and the auxiliary pairs. Each lane keeps its own state. Two inputs gate all lanes: a reception-enable from the activation sequencer and a session-active flag. While either one is low, every card-side line is held low, no host-side line is driven, and any transfer in progress is dropped. Pull-ups, level translation and activation timing belong to the surrounding logic.

Top module: `iodir_arbiter`

## Requirements
- R1: While `rst` is high, every `card_pull` bit is 1 and every `host_pull` bit is 0, whatever `rx_en` and `sess_on` are.
- R2: While `rx_en` or `sess_on` is 0, every `card_pull` bit is 1 and every `host_pull` bit is 0, and falling edges on either side do not start a transfer.
- R3: With both enables high and a lane idle, that lane drives neither line (`host_pull` and `card_pull` bits are 0).
- R4: A falling `host_in` bit sampled at a clock edge, on an idle enabled lane, makes that lane host-driven from that edge on. The lane's `card_pull` bit then equals the inverse of its `host_in` bit, and its `host_pull` bit stays 0.
- R5: A falling `card_in` bit on an idle enabled lane makes the lane card-driven. The lane's `host_pull` bit then equals the inverse of its `card_in` bit, and its `card_pull` bit stays 0.
- R6: If both lines of an idle lane fall at the same clock edge, the host side wins.
- R7: A rising edge on the winning line returns the lane to idle at that edge. A line that is already low does not start a new transfer; only a later falling edge does.
- R8: While a lane is driven from one side, level changes on the line of the other side have no effect on the lane's outputs.
- R9: Dropping `rx_en` or `sess_on` during a transfer forces the lane to idle. Raising the enables again while the former winner is still low leaves the lane idle.
- R10: Lanes are independent. Bit k of every port vector belongs to lane k, with lane 0 the data pair, and lanes may be driven in opposite directions at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable from the activation sequencer |
| sess_on | input | 1 | Card session active |
| host_in | input | NUM_LINES | Sensed host-side line levels |
| card_in | input | NUM_LINES | Sensed card-side line levels |
| host_pull | output | NUM_LINES | Pull host-side line low |
| card_pull | output | NUM_LINES | Pull card-side line low |

## Verification
Two things can land on the same clock edge: a falling edge on the host line and a falling edge on the card line of the same lane. The bench lowers both lines in one input step on an idle lane. It then expects only the card-side pull to follow the host level. After the host line rises, it expects the lane to stay idle while the card line is still low. The second collision is a disable arriving during an active transfer. The bench drops `sess_on` or `rx_en` mid-claim and expects the card-side lines to go low at once. On re-enable it expects no restart.

// File: rtl/iodir_pkg.sv
package iodir_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_HOST = 2'd1,
        DIR_CARD = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_ev_t;

    typedef struct packed {
        logic host_pull;
        logic card_pull;
    } pull_t;

    // Claim decision from an idle lane; host side takes priority on a tie.
    function automatic dir_state_e claim_dir(edge_ev_t h_ev, edge_ev_t c_ev);
        if (h_ev.fall)      return DIR_HOST;
        else if (c_ev.fall) return DIR_CARD;
        else                return DIR_IDLE;
    endfunction

    // Release condition: rising edge on the line that owns the lane.
    function automatic logic owner_released(dir_state_e st, edge_ev_t h_ev, edge_ev_t c_ev);
        case (st)
            DIR_HOST: return h_ev.rise;
            DIR_CARD: return c_ev.rise;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/iodir_edge.sv
module iodir_edge
    import iodir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    output edge_ev_t ev
);
    logic prev_q;

    // Lines idle high, so the history starts high.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end

    always_comb begin
        ev.fall = prev_q & ~level;
        ev.rise = ~prev_q & level;
    end
endmodule

// File: rtl/iodir_fsm.sv
module iodir_fsm
    import iodir_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  edge_ev_t   host_ev,
    input  edge_ev_t   card_ev,
    output dir_state_e state
);
    dir_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = DIR_IDLE;
        end else begin
            case (state_q)
                DIR_IDLE: state_d = claim_dir(host_ev, card_ev);
                DIR_HOST,
                DIR_CARD: if (owner_released(state_q, host_ev, card_ev)) state_d = DIR_IDLE;
                default:  state_d = DIR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/iodir_drive.sv
module iodir_drive
    import iodir_pkg::*;
(
    input  logic       active,
    input  dir_state_e state,
    input  logic       host_lvl,
    input  logic       card_lvl,
    output pull_t      pulls
);
    always_comb begin
        pulls = '0;
        if (!active) begin
            pulls.card_pull = 1'b1;
        end else begin
            case (state)
                DIR_HOST: pulls.card_pull = ~host_lvl;
                DIR_CARD: pulls.host_pull = ~card_lvl;
                default:  pulls = '0;
            endcase
        end
    end
endmodule

// File: rtl/iodir_arbiter.sv
module iodir_arbiter
    import iodir_pkg::*;
#(
    parameter int NUM_LINES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_en,
    input  logic                 sess_on,
    input  logic [NUM_LINES-1:0] host_in,
    input  logic [NUM_LINES-1:0] card_in,
    output logic [NUM_LINES-1:0] host_pull,
    output logic [NUM_LINES-1:0] card_pull
);
    logic active;
    assign active = rx_en & sess_on & ~rst;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_lane
        edge_ev_t   h_ev, c_ev;
        dir_state_e st;
        pull_t      pl;

        iodir_edge u_host_edge (.clk(clk), .rst(rst), .level(host_in[k]), .ev(h_ev));
        iodir_edge u_card_edge (.clk(clk), .rst(rst), .level(card_in[k]), .ev(c_ev));

        iodir_fsm u_fsm (
            .clk(clk), .rst(rst), .active(active),
            .host_ev(h_ev), .card_ev(c_ev), .state(st)
        );

        iodir_drive u_drive (
            .active(active), .state(st),
            .host_lvl(host_in[k]), .card_lvl(card_in[k]), .pulls(pl)
        );

        assign host_pull[k] = pl.host_pull;
        assign card_pull[k] = pl.card_pull;
    end
endmodule

// File: rtl/iodir_arbiter_chk.sv
module iodir_arbiter_chk #(
    parameter int NUM_LINES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_en,
    input logic                 sess_on,
    input logic [NUM_LINES-1:0] host_in,
    input logic [NUM_LINES-1:0] card_in,
    input logic [NUM_LINES-1:0] host_pull,
    input logic [NUM_LINES-1:0] card_pull
);
    always @(posedge clk) begin
        if (rst) begin
            // R1
            reset_safe_chk: assert (card_pull == '1 && host_pull == '0);
        end
    end

    // R2
    inactive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_en && sess_on) |-> (card_pull == '1 && host_pull == '0));

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
        // R4
        one_driver_chk: assert property (@(posedge clk) disable iff (rst)
            (rx_en && sess_on) |-> !(host_pull[k] && card_pull[k]));

        // R3
        quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (rx_en && sess_on && $past(rx_en && sess_on) &&
             host_in[k] && card_in[k] && $past(host_in[k]) && $past(card_in[k]))
            |-> (!host_pull[k] && !card_pull[k]));
    end
endmodule

bind iodir_arbiter iodir_arbiter_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst(rst), .rx_en(rx_en), .sess_on(sess_on),
    .host_in(host_in), .card_in(card_in),
    .host_pull(host_pull), .card_pull(card_pull)
);

// File: tb/tb_iodir_arbiter.sv
`timescale 1ns/1ps
module tb_iodir_arbiter;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_en = 1'b0;
    logic         sess_on = 1'b0;
    logic [N-1:0] host_in = '1;
    logic [N-1:0] card_in = '1;
    logic [N-1:0] host_pull, card_pull;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        logic [N-1:0] hp;
        logic [N-1:0] cp;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    iodir_arbiter #(.NUM_LINES(N)) dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .sess_on(sess_on),
        .host_in(host_in), .card_in(card_in),
        .host_pull(host_pull), .card_pull(card_pull)
    );

    // Driver: set inputs at the falling edge, queue the outputs expected after the next rising edge.
    task automatic step(input logic r, input logic en, input logic ss,
                        input logic [N-1:0] h, input logic [N-1:0] c,
                        input logic [N-1:0] ehp, input logic [N-1:0] ecp,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; rx_en = en; sess_on = ss; host_in = h; card_in = c;
        e.hp = ehp; e.cp = ecp; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: sample between edges and compare with the scoreboard head.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (host_pull !== e.hp || card_pull !== e.cp) begin
                    n_fail++;
                    $display("FAIL %s: host_pull=%b card_pull=%b expected host_pull=%b card_pull=%b",
                             e.tag, host_pull, card_pull, e.hp, e.cp);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, also with enables high
        step(1, 0, 0, 3'b111, 3'b111, 3'b000, 3'b111, "R1 reset");
        step(1, 1, 1, 3'b111, 3'b111, 3'b000, 3'b111, "R1 reset enables high");
        // R2: inactive
        step(0, 0, 1, 3'b111, 3'b111, 3'b000, 3'b111, "R2 rx_en low");
        step(0, 0, 1, 3'b110, 3'b111, 3'b000, 3'b111, "R2 host fall ignored");
        step(0, 1, 0, 3'b111, 3'b110, 3'b000, 3'b111, "R2 card fall sess off");
        // R3: enabled idle
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R3 idle");
        // R4: host claims lane 0
        step(0, 1, 1, 3'b110, 3'b111, 3'b000, 3'b001, "R4 host claim");
        // R8: card-side activity ignored
        step(0, 1, 1, 3'b110, 3'b110, 3'b000, 3'b001, "R8 card fall ignored");
        step(0, 1, 1, 3'b110, 3'b111, 3'b000, 3'b001, "R8 card rise ignored");
        // R7: release
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R7 host release");
        // R5: card claims lane 1
        step(0, 1, 1, 3'b111, 3'b101, 3'b010, 3'b000, "R5 card claim");
        step(0, 1, 1, 3'b101, 3'b101, 3'b010, 3'b000, "R8 host fall ignored");
        step(0, 1, 1, 3'b111, 3'b101, 3'b010, 3'b000, "R8 host rise ignored");
        // R10: lane 2 host-driven while lane 1 card-driven
        step(0, 1, 1, 3'b011, 3'b101, 3'b010, 3'b100, "R10 opposite lanes");
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R7 both release");
        // R6: simultaneous falls on lane 0
        step(0, 1, 1, 3'b110, 3'b110, 3'b000, 3'b001, "R6 host wins tie");
        step(0, 1, 1, 3'b111, 3'b110, 3'b000, 3'b000, "R7 low card no claim");
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R7 card high idle");
        step(0, 1, 1, 3'b111, 3'b110, 3'b001, 3'b000, "R7 fresh card claim");
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R7 card release");
        // R9: session drop during host transfer
        step(0, 1, 1, 3'b110, 3'b111, 3'b000, 3'b001, "R9 host claim");
        step(0, 1, 0, 3'b110, 3'b111, 3'b000, 3'b111, "R9 session drop");
        step(0, 1, 1, 3'b110, 3'b111, 3'b000, 3'b000, "R9 no restart");
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R9 idle after");
        // R9: enable drop during card transfer on lane 2
        step(0, 1, 1, 3'b111, 3'b011, 3'b100, 3'b000, "R9 card claim");
        step(0, 0, 1, 3'b111, 3'b011, 3'b000, 3'b111, "R9 rx_en drop");
        step(0, 1, 1, 3'b111, 3'b011, 3'b000, 3'b000, "R9 no card restart");
        step(0, 1, 1, 3'b111, 3'b111, 3'b000, 3'b000, "R3 idle end");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule